// File: doc/BRIEF.md
# Control Endpoint IN Packet Buffer

This block holds one outgoing data packet for the IN direction of a USB device's default control endpoint. Firmware loads the packet one byte at a time through a register-style write port. The bytes are not visible to the transmitter while they are being loaded. Firmware then sets bit 0 in a write to the trigger port. That write freezes the packet and presents it, with its byte count, to the serial engine.

The serial engine fetches the bytes in order through a registered read port. Once the host has answered, the engine reports a single handshake outcome. On an ACK the packet is retired, the storage becomes empty and a sticky completion flag is raised. On any other outcome (NAK or timeout) the frozen packet stays in place, and the fetch position returns to the first byte so that the identical packet can be sent again.

A second sticky flag records an attempt to load more bytes than the storage holds. Both flags are cleared from firmware by writing 1 to them. A separate clear pulse empties the storage and cancels a pending packet in one clock.

Top module: `ep0_txbuf`

## Requirements
- R1: After a synchronous reset, `pkt_rdy`, `pkt_len`, `flag_done` and `flag_ovf` are all 0.
- R2: Loaded bytes are stored in arrival order. `pkt_rdy` stays 0 while loading and while triggers with bit 0 = 0 are written.
- R3: A trigger write with bit 0 = 1, made while no packet is pending, sets `pkt_rdy` on the next clock. `pkt_len` then shows the number of bytes loaded, including a byte written in the same cycle as the trigger.
- R4: A read strobe while a packet is pending returns the next byte on `rd_data` one clock later, starting at byte 0. Strobes past `pkt_len` leave `rd_data` unchanged.
- R5: A load beyond DEPTH (8) bytes is discarded and sets `flag_ovf`. The stored bytes are unaffected, and `pkt_len` never exceeds DEPTH.
- R6: A handshake with `hs_ack` = 1 on a pending packet clears `pkt_rdy` and `pkt_len` and sets `flag_done`, all on the next clock.
- R7: A handshake with `hs_ack` = 0 keeps the packet, its length and its contents. It returns the fetch position to byte 0, and `flag_done` is not set.
- R8: A status write clears `flag_done` where bit 0 is 1 and clears `flag_ovf` where bit 1 is 1. Bits written as 0 change nothing.
- R9: When a flag's setting event and a status write clearing that flag fall in the same cycle, the flag ends up set.
- R10: A clear pulse empties the storage, cancels any pending packet and resets both positions in one clock (`pkt_rdy` = 0, `pkt_len` = 0). The next packet loads from byte 0. The flags are left as they were.
- R11: Byte loads while a packet is pending are discarded and do not alter the frozen packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Firmware byte load strobe |
| wr_byte | input | 8 | Byte to load |
| trig_wr | input | 1 | Firmware trigger write strobe |
| trig_val | input | 8 | Trigger value; bit 0 commits |
| clr | input | 1 | Empty buffer and cancel pending packet |
| stat_wr | input | 1 | Status write strobe (write 1 to clear) |
| stat_val | input | 2 | Bit 0 clears done, bit 1 clears overflow |
| rd_en | input | 1 | Serial engine byte fetch strobe |
| rd_data | output | 8 | Fetched byte, registered |
| hs_valid | input | 1 | Handshake outcome valid |
| hs_ack | input | 1 | 1 = ACK, 0 = NAK or timeout |
| pkt_rdy | output | 1 | Packet committed and available |
| pkt_len | output | 4 | Committed byte count |
| flag_done | output | 1 | Sticky transmit-complete flag |
| flag_ovf | output | 1 | Sticky overflow flag |

## Verification
Two pairs of events can land in the same cycle: an ACK handshake together with a firmware status write that clears the completion flag, and a byte load together with the committing trigger. The bench drives each pair on the same edge. It then checks that the completion flag is still set afterwards. It also checks that the reported length and the fetched data include the byte loaded alongside the trigger.

// File: rtl/ep0_txbuf_pkg.sv
package ep0_txbuf_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    logic done;
    logic ovf;
  } flag_evt_t;
endpackage

// File: rtl/txbuf_ram.sv
module txbuf_ram #(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/txbuf_seq.sv
module txbuf_seq #(
  parameter int DEPTH = 8,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          trig_wr,
  input  logic          trig_bit,
  input  logic          clr,
  input  logic          rd_en,
  input  logic          hs_valid,
  input  logic          hs_ack,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic          mem_re,
  output logic [AW-1:0] mem_raddr,
  output logic          pending,
  output logic [CW-1:0] len,
  output logic          ack_evt,
  output logic          ovf_evt
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [CW-1:0] wcnt;
  logic [CW-1:0] rptr;
  logic          wr_ok, commit_evt, rd_ok, nak_evt;

  always_comb begin
    wr_ok      = wr_en && !pending && (wcnt < FULL) && !clr;
    ovf_evt    = wr_en && !pending && (wcnt == FULL) && !clr;
    commit_evt = trig_wr && trig_bit && !pending && !clr;
    rd_ok      = rd_en && pending && (rptr < len) && !clr;
    ack_evt    = hs_valid && hs_ack && pending && !clr;
    nak_evt    = hs_valid && !hs_ack && pending && !clr;
    mem_we     = wr_ok;
    mem_waddr  = wcnt[AW-1:0];
    mem_re     = rd_ok;
    mem_raddr  = rptr[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wcnt    <= '0;
      rptr    <= '0;
      len     <= '0;
      pending <= 1'b0;
    end else if (ack_evt) begin
      wcnt    <= '0;
      rptr    <= '0;
      len     <= '0;
      pending <= 1'b0;
    end else begin
      if (wr_ok) wcnt <= wcnt + 1'b1;
      if (commit_evt) begin
        pending <= 1'b1;
        len     <= wcnt + CW'(wr_ok);
        rptr    <= '0;
      end
      if (nak_evt)    rptr <= '0;
      else if (rd_ok) rptr <= rptr + 1'b1;
    end
  end
endmodule

// File: rtl/txbuf_flags.sv
module txbuf_flags
  import ep0_txbuf_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  flag_evt_t set_evt,
  input  logic      stat_wr,
  input  logic [1:0] stat_val,
  output logic      done,
  output logic      ovf
);
  always_ff @(posedge clk) begin
    if (rst) begin
      done <= 1'b0;
      ovf  <= 1'b0;
    end else begin
      if (set_evt.done)              done <= 1'b1;
      else if (stat_wr && stat_val[0]) done <= 1'b0;
      if (set_evt.ovf)               ovf  <= 1'b1;
      else if (stat_wr && stat_val[1]) ovf  <= 1'b0;
    end
  end
endmodule

// File: rtl/ep0_txbuf.sv
module ep0_txbuf
  import ep0_txbuf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [7:0]    wr_byte,
  input  logic          trig_wr,
  input  logic [7:0]    trig_val,
  input  logic          clr,
  input  logic          stat_wr,
  input  logic [1:0]    stat_val,
  input  logic          rd_en,
  output logic [7:0]    rd_data,
  input  logic          hs_valid,
  input  logic          hs_ack,
  output logic          pkt_rdy,
  output logic [CW-1:0] pkt_len,
  output logic          flag_done,
  output logic          flag_ovf
);
  logic          mem_we, mem_re, ack_evt, ovf_evt;
  logic [AW-1:0] mem_waddr, mem_raddr;
  flag_evt_t     evts;

  txbuf_seq #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .trig_wr  (trig_wr),
    .trig_bit (trig_val[0]),
    .clr      (clr),
    .rd_en    (rd_en),
    .hs_valid (hs_valid),
    .hs_ack   (hs_ack),
    .mem_we   (mem_we),
    .mem_waddr(mem_waddr),
    .mem_re   (mem_re),
    .mem_raddr(mem_raddr),
    .pending  (pkt_rdy),
    .len      (pkt_len),
    .ack_evt  (ack_evt),
    .ovf_evt  (ovf_evt)
  );

  txbuf_ram #(.AW(AW), .DW(BYTE_W)) u_ram (
    .clk  (clk),
    .we   (mem_we),
    .waddr(mem_waddr),
    .wdata(wr_byte),
    .re   (mem_re),
    .raddr(mem_raddr),
    .rdata(rd_data)
  );

  always_comb begin
    evts.done = ack_evt;
    evts.ovf  = ovf_evt;
  end

  txbuf_flags u_flags (
    .clk     (clk),
    .rst     (rst),
    .set_evt (evts),
    .stat_wr (stat_wr),
    .stat_val(stat_val),
    .done    (flag_done),
    .ovf     (flag_ovf)
  );
endmodule

// File: rtl/ep0_txbuf_chk.sv
module ep0_txbuf_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic          trig_wr,
  input logic [7:0]    trig_val,
  input logic          clr,
  input logic          stat_wr,
  input logic [1:0]    stat_val,
  input logic          hs_valid,
  input logic          hs_ack,
  input logic          pkt_rdy,
  input logic [CW-1:0] pkt_len,
  input logic          flag_done,
  input logic          flag_ovf
);
  // R3
  commit_chk: assert property (@(posedge clk) disable iff (rst)
    (trig_wr && trig_val[0] && !pkt_rdy && !clr) |=> pkt_rdy);

  // R2
  no_early_rdy_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pkt_rdy) |-> $past(trig_wr && trig_val[0]));

  // R6
  ack_retire_chk: assert property (@(posedge clk) disable iff (rst)
    (hs_valid && hs_ack && pkt_rdy && !clr) |=> (!pkt_rdy && flag_done && pkt_len == '0));

  // R7
  nak_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (hs_valid && !hs_ack && pkt_rdy && !clr && !trig_wr) |=> (pkt_rdy && $stable(pkt_len)));

  // R10
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!pkt_rdy && pkt_len == '0));

  // R5
  len_bound_chk: assert property (@(posedge clk) disable iff (rst)
    pkt_len <= CW'(DEPTH));

  // R8
  w1c_done_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && stat_val[0] && !(hs_valid && hs_ack && pkt_rdy && !clr)) |=> !flag_done);

  // R8
  w1c_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && stat_val[1] && !wr_en) |=> !flag_ovf);
endmodule

bind ep0_txbuf ep0_txbuf_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .trig_wr  (trig_wr),
  .trig_val (trig_val),
  .clr      (clr),
  .stat_wr  (stat_wr),
  .stat_val (stat_val),
  .hs_valid (hs_valid),
  .hs_ack   (hs_ack),
  .pkt_rdy  (pkt_rdy),
  .pkt_len  (pkt_len),
  .flag_done(flag_done),
  .flag_ovf (flag_ovf)
);

// File: tb/ep0_txbuf_test.sv
`timescale 1ns/1ps
module ep0_txbuf_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, trig_wr = 1'b0, clr = 1'b0, stat_wr = 1'b0;
  logic       rd_en = 1'b0, hs_valid = 1'b0, hs_ack = 1'b0;
  logic [7:0] wr_byte = '0, trig_val = '0;
  logic [1:0] stat_val = '0;
  logic [7:0] rd_data;
  logic       pkt_rdy, flag_done, flag_ovf;
  logic [3:0] pkt_len;

  int runs = 0;
  int fails = 0;

  always #4 clk = ~clk;

  ep0_txbuf uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_byte(wr_byte),
    .trig_wr(trig_wr), .trig_val(trig_val), .clr(clr),
    .stat_wr(stat_wr), .stat_val(stat_val), .rd_en(rd_en), .rd_data(rd_data),
    .hs_valid(hs_valid), .hs_ack(hs_ack), .pkt_rdy(pkt_rdy), .pkt_len(pkt_len),
    .flag_done(flag_done), .flag_ovf(flag_ovf)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    runs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // inputs change at negedge; one call = one clock edge consumed
  task automatic step();
    @(negedge clk);
    wr_en = 0; trig_wr = 0; clr = 0; stat_wr = 0; rd_en = 0; hs_valid = 0;
  endtask

  task automatic load(input logic [7:0] b);
    wr_en = 1; wr_byte = b; step();
  endtask

  task automatic trig(input logic [7:0] v);
    trig_wr = 1; trig_val = v; step();
  endtask

  task automatic fetch(input string req, input logic [7:0] exp);
    rd_en = 1; step();
    chk(req, "rd_data", int'(rd_data), int'(exp));
  endtask

  task automatic hshake(input logic ack);
    hs_valid = 1; hs_ack = ack; step();
  endtask

  task automatic w1c(input logic [1:0] v);
    stat_wr = 1; stat_val = v; step();
  endtask

  task automatic t_reset();
    rst = 1; step(); step(); rst = 0;
    chk("R1", "pkt_rdy", int'(pkt_rdy), 0);
    chk("R1", "pkt_len", int'(pkt_len), 0);
    chk("R1", "flag_done", int'(flag_done), 0);
    chk("R1", "flag_ovf", int'(flag_ovf), 0);
  endtask

  task automatic t_basic();
    load(8'hA1); load(8'hB2); load(8'hC3);
    chk("R2", "pkt_rdy while loading", int'(pkt_rdy), 0);
    trig(8'h02);
    chk("R2", "pkt_rdy after bit0=0 trigger", int'(pkt_rdy), 0);
    trig(8'h01);
    chk("R3", "pkt_rdy", int'(pkt_rdy), 1);
    chk("R3", "pkt_len", int'(pkt_len), 3);
    fetch("R4", 8'hA1); fetch("R4", 8'hB2); fetch("R4", 8'hC3);
    fetch("R4", 8'hC3);
    hshake(1'b1);
    chk("R6", "pkt_rdy", int'(pkt_rdy), 0);
    chk("R6", "pkt_len", int'(pkt_len), 0);
    chk("R6", "flag_done", int'(flag_done), 1);
    w1c(2'b10);
    chk("R8", "done kept on bit0=0", int'(flag_done), 1);
    w1c(2'b01);
    chk("R8", "done cleared", int'(flag_done), 0);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 9; i++) load(8'h10 + 8'(i));
    chk("R5", "flag_ovf", int'(flag_ovf), 1);
    trig(8'h01);
    chk("R5", "pkt_len", int'(pkt_len), 8);
    for (int i = 0; i < 8; i++) fetch("R5", 8'h10 + 8'(i));
    w1c(2'b01);
    chk("R8", "ovf kept on bit1=0", int'(flag_ovf), 1);
    w1c(2'b10);
    chk("R8", "ovf cleared", int'(flag_ovf), 0);
    hshake(1'b1);
    w1c(2'b01);
  endtask

  task automatic t_nak();
    load(8'h5A); load(8'h6B); trig(8'h01);
    fetch("R7", 8'h5A); fetch("R7", 8'h6B);
    hshake(1'b0);
    chk("R7", "pkt_rdy", int'(pkt_rdy), 1);
    chk("R7", "pkt_len", int'(pkt_len), 2);
    chk("R7", "flag_done", int'(flag_done), 0);
    load(8'hEE);
    chk("R11", "pkt_len after load", int'(pkt_len), 2);
    fetch("R7", 8'h5A); fetch("R11", 8'h6B);
    hshake(1'b1);
    chk("R6", "flag_done after retry", int'(flag_done), 1);
  endtask

  task automatic t_collide();
    w1c(2'b01);
    load(8'h77); trig(8'h01);
    hs_valid = 1; hs_ack = 1; stat_wr = 1; stat_val = 2'b01; step();
    chk("R9", "done wins over clear", int'(flag_done), 1);
    w1c(2'b01);
    chk("R8", "done cleared", int'(flag_done), 0);
    load(8'h31);
    wr_en = 1; wr_byte = 8'h42; trig_wr = 1; trig_val = 8'h01; step();
    chk("R3", "len with same-cycle load", int'(pkt_len), 2);
    fetch("R3", 8'h31); fetch("R3", 8'h42);
    hshake(1'b1);
    w1c(2'b01);
  endtask

  task automatic t_clear();
    for (int i = 0; i < 9; i++) load(8'h80 + 8'(i));
    trig(8'h01);
    clr = 1; step();
    chk("R10", "pkt_rdy", int'(pkt_rdy), 0);
    chk("R10", "pkt_len", int'(pkt_len), 0);
    chk("R10", "ovf unchanged", int'(flag_ovf), 1);
    load(8'hD4); trig(8'h01);
    chk("R10", "pkt_len after reload", int'(pkt_len), 1);
    fetch("R10", 8'hD4);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; runs++;
    $display("FAIL R1 watchdog act=hung exp=finished");
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    step();
    t_reset();
    t_basic();
    t_overflow();
    t_nak();
    t_collide();
    t_clear();
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule